// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary of a small processor core, whether the core must enter a handler, and it carries out that entry. Three kinds of request compete: a reset request, a non-maskable interrupt (NMI) and six maskable sources. The block owns the interrupt-control bits of the processor status word (PSW) and the exception cause register. It also owns two pairs of return-state save registers: one pair for maskable entries and one pair for NMI entries. When it takes an entry, it issues a one-cycle redirect together with the new fetch address.

The core raises `step_i` for one cycle at each instruction boundary and presents the address of the next instruction on `pc_i`. Requests are only looked at in such a cycle. An NMI that arrives while an NMI handler is still running is not lost. It is held as a single pending flag and taken once the core signals the end of that handler with `nmi_ret_i`. The core can also load the PSW through a write strobe, for example to unmask interrupts again.

Top module: `irq_entry_seq`

## Requirements
- R1: After the reset input is released, the PSW reads 0x20, the cause register is 0, all save registers are 0, the pending flag is 0 and no redirect is signalled. PSW bits are fixed as follows: bit 5 is interrupt-disable (ID), bit 6 is exception-in-progress (EP), bit 7 is NMI-in-progress (NP).
- R2: A boundary with the reset request set produces a redirect to address 0. It also sets the PSW to 0x20, clears the cause register and clears the pending flag, and it leaves all save registers unchanged.
- R3: A boundary that takes an NMI saves `pc_i` and the old PSW into the NMI save pair. It then clears the upper 16 cause bits, ORs 0x10 into the lower 16, sets ID and NP, clears EP and redirects to 0x10.
- R4: An NMI request at a boundary where NP is set produces no NMI entry and leaves the NMI save pair untouched. It only sets the pending flag, and repeated requests still leave a single flag.
- R5: At a boundary where NP is clear and the pending flag is set, the NMI is taken even with no request present, and the pending flag is cleared.
- R6: A boundary that takes maskable source k (k = 0..5) saves `pc_i` and the old PSW into the maskable save pair. It writes the vector 0x80 + 0x10*k into the lower 16 cause bits, keeps the upper 16, sets ID, clears EP and redirects to that vector.
- R7: Maskable requests are ignored while ID is set: there is no redirect, no state changes and nothing is remembered. Reset and NMI requests do not depend on ID.
- R8: When several requests meet at one boundary, reset wins over NMI, NMI wins over maskable sources, and the lowest-numbered maskable source wins over higher ones. An NMI deferred by R4 does not block a maskable entry in the same boundary.
- R9: The redirect pulse and the new state appear exactly one clock after the boundary cycle, for one clock. Cycles without `step_i` never cause an entry, whatever the requests.
- R10: `nmi_ret_i` clears NP. A boundary in the same cycle still sees NP set, so a pending NMI is taken no earlier than the next boundary.
- R11: `psw_we_i` loads `psw_wd_i` into the PSW when no entry happens in that cycle. If an entry happens in that cycle, the write is discarded, and the saved PSW is the value from before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Return address presented at the boundary |
| rst_req_i | input | 1 | Reset request |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| src_req_i | input | 6 | Maskable source requests, bit k is source k |
| nmi_ret_i | input | 1 | End of NMI handler, clears NP |
| psw_we_i | input | 1 | PSW load strobe from the core |
| psw_wd_i | input | 8 | PSW load value |
| redirect_o | output | 1 | One-cycle entry pulse |
| redirect_pc_o | output | 32 | Handler address, valid with redirect_o |
| psw_o | output | 8 | Current PSW |
| src_save_pc_o | output | 32 | Return address saved on maskable entry |
| src_save_psw_o | output | 8 | PSW saved on maskable entry |
| nmi_save_pc_o | output | 32 | Return address saved on NMI entry |
| nmi_save_psw_o | output | 8 | PSW saved on NMI entry |
| cause_o | output | 32 | Exception cause register |
| nmi_pending_o | output | 1 | Deferred NMI waiting |

## Verification
The interesting collisions happen when two functions act in the same boundary cycle. One case is an NMI deferred into the pending flag while a maskable source is taken. Another is an NMI-return strobe landing on the boundary that would otherwise take the pending NMI. The bench builds both by first loading a PSW with NP set and ID clear, and then by strobing the return together with a boundary. A behavioural model is compared against the design after every clock. Directed checks also confirm that the pending entry appears only at the following boundary, and that a PSW write landing on an entry cycle is discarded.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int PC_W          = 32,
  parameter int PSW_W         = 8,
  parameter int N_SRC         = 6,
  parameter int CAUSE_W       = 32,
  parameter int ID_BIT        = 5,
  parameter int EP_BIT        = 6,
  parameter int NP_BIT        = 7,
  parameter logic [PSW_W-1:0] PSW_RST = 'h20,
  parameter int NMI_VEC       = 'h10,
  parameter int NMI_CODE      = 'h10,
  parameter int SRC_VEC_BASE  = 'h80,
  parameter int SRC_VEC_STEP  = 'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               rst_req_i,
  input  logic               nmi_req_i,
  input  logic [N_SRC-1:0]   src_req_i,
  input  logic               nmi_ret_i,
  input  logic               psw_we_i,
  input  logic [PSW_W-1:0]   psw_wd_i,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [PSW_W-1:0]   psw_o,
  output logic [PC_W-1:0]    src_save_pc_o,
  output logic [PSW_W-1:0]   src_save_psw_o,
  output logic [PC_W-1:0]    nmi_save_pc_o,
  output logic [PSW_W-1:0]   nmi_save_psw_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               nmi_pending_o
);
  localparam int HALF  = CAUSE_W / 2;
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [PC_W-1:0] NMI_PC  = PC_W'(NMI_VEC);
  localparam logic [PC_W-1:0] VBASE   = PC_W'(SRC_VEC_BASE);
  localparam logic [PC_W-1:0] VSTEP   = PC_W'(SRC_VEC_STEP);
  localparam logic [HALF-1:0] NCODE   = HALF'(NMI_CODE);

  logic               take_rst, take_nmi, take_src, defer_nmi, entry;
  logic               src_hit;
  logic [IDX_W-1:0]   src_sel;
  logic [PC_W-1:0]    src_vec;
  logic [PSW_W-1:0]   psw_base, psw_next;

  assign take_rst  = step_i & rst_req_i;
  assign take_nmi  = step_i & ~rst_req_i & (nmi_req_i | nmi_pending_o) & ~psw_o[NP_BIT];
  assign defer_nmi = step_i & ~rst_req_i & nmi_req_i & psw_o[NP_BIT];
  assign take_src  = step_i & ~rst_req_i & ~take_nmi & ~psw_o[ID_BIT] & src_hit;
  assign entry     = take_rst | take_nmi | take_src;

  always_comb begin
    src_hit = 1'b0;
    src_sel = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (src_req_i[k]) begin
        src_hit = 1'b1;
        src_sel = IDX_W'(k);
      end
    end
  end

  assign src_vec = VBASE + PC_W'(src_sel) * VSTEP;

  always_comb begin
    psw_base = (psw_we_i & ~entry) ? psw_wd_i : psw_o;
    if (nmi_ret_i) psw_base[NP_BIT] = 1'b0;
    psw_next = psw_base;
    if (take_nmi | take_src) begin
      psw_next[ID_BIT] = 1'b1;
      psw_next[EP_BIT] = 1'b0;
    end
    if (take_nmi) psw_next[NP_BIT] = 1'b1;
    if (take_rst) psw_next = PSW_RST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o     <= 1'b0;
      redirect_pc_o  <= '0;
      psw_o          <= PSW_RST;
      src_save_pc_o  <= '0;
      src_save_psw_o <= '0;
      nmi_save_pc_o  <= '0;
      nmi_save_psw_o <= '0;
      cause_o        <= '0;
      nmi_pending_o  <= 1'b0;
    end else begin
      redirect_o <= entry;
      psw_o      <= psw_next;
      if (take_rst) begin
        redirect_pc_o <= '0;
        cause_o       <= '0;
        nmi_pending_o <= 1'b0;
      end else if (take_nmi) begin
        redirect_pc_o  <= NMI_PC;
        nmi_save_pc_o  <= pc_i;
        nmi_save_psw_o <= psw_o;
        cause_o        <= {{HALF{1'b0}}, cause_o[HALF-1:0] | NCODE};
        nmi_pending_o  <= 1'b0;
      end else begin
        if (take_src) begin
          redirect_pc_o  <= src_vec;
          src_save_pc_o  <= pc_i;
          src_save_psw_o <= psw_o;
          cause_o        <= {cause_o[CAUSE_W-1:HALF], src_vec[HALF-1:0]};
        end
        if (defer_nmi) nmi_pending_o <= 1'b1;
      end
    end
  end

  AST_STEP_GATES_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !redirect_o); // R9
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && rst_req_i) |=> (redirect_o && redirect_pc_o == '0 && psw_o == PSW_RST
                              && cause_o == '0 && !nmi_pending_o)); // R2
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (psw_o[ID_BIT] && !psw_o[EP_BIT])); // R3
  AST_NMI_MARKS_NP: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && redirect_pc_o == NMI_PC) |-> psw_o[NP_BIT]); // R3
  AST_NMI_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !rst_req_i && nmi_req_i && psw_o[NP_BIT] && !nmi_ret_i && !psw_we_i)
      |=> (nmi_pending_o && psw_o[NP_BIT])); // R4
  AST_PEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !rst_req_i && nmi_pending_o && !psw_o[NP_BIT])
      |=> (redirect_o && redirect_pc_o == NMI_PC && !nmi_pending_o)); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && psw_o[ID_BIT] && !rst_req_i && !nmi_req_i && !nmi_pending_o)
      |=> !redirect_o); // R7
  AST_RET_DELAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && nmi_ret_i && psw_o[NP_BIT] && !rst_req_i)
      |=> (!psw_o[NP_BIT] && !(redirect_o && redirect_pc_o == NMI_PC))); // R10
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, rst_req_i = 1'b0, nmi_req_i = 1'b0, nmi_ret_i = 1'b0, psw_we_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  src_req_i = '0;
  logic [7:0]  psw_wd_i = '0;
  logic        redirect_o, nmi_pending_o;
  logic [31:0] redirect_pc_o, src_save_pc_o, nmi_save_pc_o, cause_o;
  logic [7:0]  psw_o, src_save_psw_o, nmi_save_psw_o;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .pc_i(pc_i), .rst_req_i(rst_req_i),
    .nmi_req_i(nmi_req_i), .src_req_i(src_req_i), .nmi_ret_i(nmi_ret_i),
    .psw_we_i(psw_we_i), .psw_wd_i(psw_wd_i), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .psw_o(psw_o), .src_save_pc_o(src_save_pc_o),
    .src_save_psw_o(src_save_psw_o), .nmi_save_pc_o(nmi_save_pc_o),
    .nmi_save_psw_o(nmi_save_psw_o), .cause_o(cause_o), .nmi_pending_o(nmi_pending_o));

  // behavioural reference model
  bit          m_redir, m_pend;
  logic [31:0] m_rpc, m_ipc, m_npc, m_cause;
  logic [7:0]  m_psw, m_ipsw, m_npsw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_redir = 0; m_pend = 0; m_rpc = 0; m_ipc = 0; m_npc = 0; m_cause = 0;
      m_psw = 8'h20; m_ipsw = 0; m_npsw = 0;
    end else begin
      bit tr, tn, df;
      int k;
      logic [7:0] np;
      tr = step_i && rst_req_i;
      tn = step_i && !tr && (nmi_req_i || m_pend) && !m_psw[7];
      df = step_i && !tr && nmi_req_i && m_psw[7];
      k = -1;
      if (step_i && !tr && !tn && !m_psw[5])
        for (int i = 0; i < 6; i++) if (k < 0 && src_req_i[i]) k = i;
      np = (psw_we_i && !(tr || tn || k >= 0)) ? psw_wd_i : m_psw;
      if (nmi_ret_i) np[7] = 0;
      m_redir = tr || tn || (k >= 0);
      if (tr) begin
        m_rpc = 0; m_cause = 0; m_pend = 0; np = 8'h20;
      end else if (tn) begin
        m_rpc = 32'h10; m_npc = pc_i; m_npsw = m_psw;
        m_cause = (m_cause & 32'h0000_FFFF) | 32'h10;
        np = (np | 8'hA0) & 8'hBF; m_pend = 0;
      end else begin
        if (k >= 0) begin
          m_rpc = 32'h80 + 32'h10 * k; m_ipc = pc_i; m_ipsw = m_psw;
          m_cause = (m_cause & 32'hFFFF_0000) | m_rpc;
          np = (np | 8'h20) & 8'hBF;
        end
        if (df) m_pend = 1;
      end
      m_psw = np;
    end
  end

  task automatic ck(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    ck(cur_req, "redirect", {31'b0, redirect_o}, {31'b0, m_redir});
    if (m_redir) ck(cur_req, "redirect_pc", redirect_pc_o, m_rpc);
    ck(cur_req, "psw", {24'b0, psw_o}, {24'b0, m_psw});
    ck(cur_req, "cause", cause_o, m_cause);
    ck(cur_req, "pending", {31'b0, nmi_pending_o}, {31'b0, m_pend});
    ck(cur_req, "src_save", src_save_pc_o ^ {24'b0, src_save_psw_o}, m_ipc ^ {24'b0, m_ipsw});
    ck(cur_req, "nmi_save", nmi_save_pc_o ^ {24'b0, nmi_save_psw_o}, m_npc ^ {24'b0, m_npsw});
  end

  task automatic go(input bit st, input bit rq, input bit nm, input logic [5:0] iq,
                    input bit rt, input bit we, input logic [7:0] wd, input logic [31:0] pc);
    @(negedge clk);
    step_i = st; rst_req_i = rq; nmi_req_i = nm; src_req_i = iq;
    nmi_ret_i = rt; psw_we_i = we; psw_wd_i = wd; pc_i = pc;
    @(posedge clk); #1;
    step_i = 0; rst_req_i = 0; nmi_req_i = 0; src_req_i = 0;
    nmi_ret_i = 0; psw_we_i = 0; psw_wd_i = 0;
  endtask

  task automatic wr_psw(input logic [7:0] v);
    go(0, 0, 0, 6'h0, 0, 1, v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    ck("R1", "psw", {24'b0, psw_o}, 32'h20);
    ck("R1", "cause", cause_o, 32'h0);
    ck("R1", "redirect", {31'b0, redirect_o}, 32'h0);
    ck("R1", "pending", {31'b0, nmi_pending_o}, 32'h0);

    cur_req = "R7";
    go(1, 0, 0, 6'h3F, 0, 0, 8'h0, 32'h100);
    ck("R7", "masked no redirect", {31'b0, redirect_o}, 32'h0);

    cur_req = "R11";
    wr_psw(8'h00);
    ck("R11", "psw load", {24'b0, psw_o}, 32'h00);

    cur_req = "R6";
    go(1, 0, 0, 6'b101000, 0, 0, 8'h0, 32'h200);
    ck("R6", "vec", redirect_pc_o, 32'hB0);
    ck("R8", "lowest source wins", {31'b0, redirect_o}, 32'h1);
    ck("R6", "save pc", src_save_pc_o, 32'h200);
    ck("R6", "cause", cause_o, 32'hB0);
    ck("R6", "psw", {24'b0, psw_o}, 32'h20);

    cur_req = "R7";
    go(1, 0, 0, 6'h3F, 0, 0, 8'h0, 32'h204);
    ck("R7", "ID set blocks", {31'b0, redirect_o}, 32'h0);
    ck("R7", "cause kept", cause_o, 32'hB0);

    cur_req = "R8";
    wr_psw(8'h00);
    go(1, 0, 0, 6'h3F, 0, 0, 8'h0, 32'h300);
    ck("R8", "source 0 first", redirect_pc_o, 32'h80);

    cur_req = "R3";
    wr_psw(8'h00);
    go(1, 0, 1, 6'h01, 0, 0, 8'h0, 32'h400);
    ck("R8", "nmi over source", redirect_pc_o, 32'h10);
    ck("R3", "nmi save pc", nmi_save_pc_o, 32'h400);
    ck("R3", "cause", cause_o, 32'h90);
    ck("R3", "psw", {24'b0, psw_o}, 32'hA0);

    cur_req = "R4";
    wr_psw(8'h80);
    go(1, 0, 1, 6'b100000, 0, 0, 8'h0, 32'h500);
    ck("R4", "pending set", {31'b0, nmi_pending_o}, 32'h1);
    ck("R8", "source taken beside deferred nmi", redirect_pc_o, 32'hD0);
    ck("R4", "nmi save untouched", nmi_save_pc_o, 32'h400);
    go(1, 0, 1, 6'h0, 0, 0, 8'h0, 32'h504);
    ck("R4", "still one pending, no entry", {30'b0, redirect_o, nmi_pending_o}, 32'h1);

    cur_req = "R10";
    go(1, 0, 0, 6'h0, 1, 0, 8'h0, 32'h508);
    ck("R10", "no entry on return boundary", {31'b0, redirect_o}, 32'h0);
    ck("R10", "NP cleared", {24'b0, psw_o}, 32'h20);

    cur_req = "R5";
    go(1, 0, 0, 6'h0, 0, 0, 8'h0, 32'h50C);
    ck("R5", "pending taken", redirect_pc_o, 32'h10);
    ck("R5", "pending cleared", {31'b0, nmi_pending_o}, 32'h0);
    ck("R5", "save pc", nmi_save_pc_o, 32'h50C);

    cur_req = "R9";
    go(0, 1, 1, 6'h3F, 0, 0, 8'h0, 32'h510);
    ck("R9", "no step no entry", {31'b0, redirect_o}, 32'h0);
    @(posedge clk); #1;
    ck("R9", "pulse one cycle", {31'b0, redirect_o}, 32'h0);

    cur_req = "R2";
    go(1, 1, 1, 6'h3F, 0, 0, 8'h0, 32'h600);
    ck("R2", "reset vec", redirect_pc_o, 32'h0);
    ck("R2", "psw", {24'b0, psw_o}, 32'h20);
    ck("R2", "saves kept", nmi_save_pc_o ^ src_save_pc_o, 32'h50C ^ 32'h500);

    cur_req = "R11";
    wr_psw(8'h00);
    go(1, 0, 0, 6'h02, 0, 1, 8'hC0, 32'h700);
    ck("R11", "write discarded on entry", {24'b0, psw_o}, 32'h20);
    ck("R11", "saved pre-write psw", {24'b0, src_save_psw_o}, 32'h00);
    ck("R6", "source 1 vec", redirect_pc_o, 32'h90);

    repeat (2) @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule